// File: doc/BRIEF.md
# Cascadable serial configuration bit streamer

This block is the read side of a serial configuration memory. A programmable logic device drives the clock and pulls one stored bit per cycle from it. The bits come out in ascending address order for as long as chip enable is asserted and the combined reset/output-enable pin is away from its active level. The bit array is filled through a plain parallel load port, one bit per write. A stored polarity bit sets which level of the reset/output-enable pin counts as active, so the pin can connect straight to either sense of the loader's reset line.

The bit array holds `2**ADDR_W` bits. The address counter only clears when the reset/output-enable pin reaches its active level, or when the stream runs out. When the stream runs out, the counter wraps to zero and the block goes quiet. If the array is large enough to take part in a chain (`ADDR_W > SMALLEST_AW`), a low-active cascade-enable output then passes the stream to the next device. The smallest size never cascades.

Top module: `cfg_bit_streamer`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the address counter is 0, the stream is not exhausted, the polarity bit is 1, `ceo_no` is 1, and `data_vld_o` is 0 while `ce_ni` is 1.
- R2: On a rising edge with `ld_we_i` = 1, bit `ld_bit_i` is stored at address `ld_addr_i`, and the stream delivers it from that address afterwards. The read of an address in the cycle it is written returns its old value.
- R3: While `ce_ni` = 0, the reset/output-enable pin is inactive and the stream is not exhausted, `data_vld_o` = 1 and `data_o` shows the bit at the current address. The address rises by one at each rising edge, so bits come out as addresses 0, 1, 2, ...
- R4: `rst_oe_i` is sampled on the rising clock edge. In any cycle where it is at the active level, `data_vld_o` = 0 and `data_o` = 0, and the next edge clears the address to 0 and clears the exhausted state.
- R5: The polarity bit is written by `pol_we_i` with value `pol_bit_i`. When it is 1, `rst_oe_i` = 1 is the active level. When it is 0, `rst_oe_i` = 0 is the active level. A newly written value takes effect from the following cycle.
- R6: While `ce_ni` = 1, `data_vld_o` = 0, `data_o` = 0 and the address holds. A stream that was paused or aborted resumes from the held address.
- R7: The edge that reads address `2**ADDR_W - 1` sets the exhausted state. From the next cycle on, `data_vld_o` = 0. In a cascading configuration, `ceo_no` = 0 until the reset/output-enable pin reaches its active level.
- R8: When `ADDR_W <= SMALLEST_AW`, `ceo_no` stays 1 at all times. The stream still stops after the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock from the configuring device, rising edge |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| ce_ni | input | 1 | Chip enable, active low |
| rst_oe_i | input | 1 | Reset/output-enable pin, active level set by the polarity bit |
| ld_we_i | input | 1 | Load port write strobe |
| ld_addr_i | input | ADDR_W | Load port bit address |
| ld_bit_i | input | 1 | Load port data bit |
| pol_we_i | input | 1 | Polarity bit write strobe |
| pol_bit_i | input | 1 | New polarity value (1 = high-active reset) |
| data_o | output | 1 | Serial data bit, 0 when idle |
| data_vld_o | output | 1 | High when data_o carries a stream bit |
| ceo_no | output | 1 | Cascade enable to the next device, active low |

## Verification
The bench pauses the stream part way through and checks that it resumes at the held address. A design that cleared or advanced the counter while chip enable is high would shift the whole bit sequence. It asserts reset/output-enable in mid-stream under both polarity settings, which catches a design that used a fixed polarity or let the polarity write act in the same cycle. It runs past the final address on a cascading instance and a non-cascading instance side by side. A wrong end-of-stream compare would release the cascade output one cycle early or late, keep streaming after the end, or drive the cascade output on the smallest size. It also rewrites bits while the stream is running, which exposes write-versus-read ordering faults.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic {
    POL_LOW_ACTIVE  = 1'b0,
    POL_HIGH_ACTIVE = 1'b1
  } rst_pol_e;

  localparam rst_pol_e POL_RESET_VAL = POL_HIGH_ACTIVE;

endpackage

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wbit_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rbit_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == ADDR_W'(w))) bits_q[w] <= wbit_i;
    end
  end

  assign rbit_o = bits_q[raddr_i];

endmodule

// File: rtl/cfg_pol_reg.sv
module cfg_pol_reg
  import cfg_stream_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     bit_i,
  input  logic     pin_i,
  output rst_pol_e pol_o,
  output logic     active_o
);
  rst_pol_e pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pol_q <= POL_RESET_VAL;
    else if (we_i) pol_q <= rst_pol_e'(bit_i);
  end

  assign pol_o    = pol_q;
  assign active_o = (pol_q == POL_HIGH_ACTIVE) ? pin_i : ~pin_i;

endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      if (addr_q == LAST_ADDR) begin
        addr_q <= '0;
        done_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage #(
  parameter bit CASCADE_EN = 1'b1
) (
  input  logic enable_i,
  input  logic done_i,
  input  logic rbit_i,
  output logic data_o,
  output logic data_vld_o,
  output logic ceo_no
);
  assign data_vld_o = enable_i & ~done_i;
  assign data_o     = data_vld_o & rbit_i;

  if (CASCADE_EN) begin : g_casc
    assign ceo_no = ~done_i;
  end else begin : g_no_casc
    assign ceo_no = 1'b1;
  end

endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
  import cfg_stream_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SMALLEST_AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              rst_oe_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              ld_bit_i,
  input  logic              pol_we_i,
  input  logic              pol_bit_i,
  output logic              data_o,
  output logic              data_vld_o,
  output logic              ceo_no
);
  localparam bit CASCADE_EN = (ADDR_W > SMALLEST_AW);

  rst_pol_e          pol_q;
  logic              rst_act;
  logic              step;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              rbit;

  cfg_pol_reg u_pol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pol_we_i),
    .bit_i   (pol_bit_i),
    .pin_i   (rst_oe_i),
    .pol_o   (pol_q),
    .active_o(rst_act)
  );

  assign step = ~ce_ni & ~rst_act;

  cfg_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(rst_act),
    .step_i (step),
    .addr_o (addr_q),
    .done_o (done_q)
  );

  cfg_bit_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (ld_we_i),
    .waddr_i(ld_addr_i),
    .wbit_i (ld_bit_i),
    .raddr_i(addr_q),
    .rbit_o (rbit)
  );

  cfg_out_stage #(.CASCADE_EN(CASCADE_EN)) u_out (
    .enable_i  (step),
    .done_i    (done_q),
    .rbit_i    (rbit),
    .data_o    (data_o),
    .data_vld_o(data_vld_o),
    .ceo_no    (ceo_no)
  );

endmodule

// File: rtl/cfg_bit_streamer_chk.sv
module cfg_bit_streamer_chk #(
  parameter int ADDR_W      = 8,
  parameter int SMALLEST_AW = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              pol_we_i,
  input logic              pol_bit_i,
  input logic              data_o,
  input logic              data_vld_o,
  input logic              ceo_no,
  input logic              pol_q,
  input logic              rst_act,
  input logic [ADDR_W-1:0] addr_q,
  input logic              done_q
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  p_ce_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_vld_o && !data_o));

  p_ce_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !rst_act) |=> $stable(addr_q));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act |=> (addr_q == '0 && !done_q && ceo_no));

  p_rst_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act |-> !data_vld_o);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !rst_act && !done_q && addr_q != LAST_ADDR)
      |=> (addr_q == $past(addr_q) + 1'b1));

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !rst_act && !done_q && addr_q == LAST_ADDR) |=> (done_q && !data_vld_o));

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rst_act) |=> done_q);

  p_ceo_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_vld_o);

  p_pol_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_we_i |=> (pol_q == $past(pol_bit_i)));

  if (ADDR_W <= SMALLEST_AW) begin : g_nc
    p_no_cascade_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ceo_no);
  end

endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(
  .ADDR_W(ADDR_W),
  .SMALLEST_AW(SMALLEST_AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .pol_we_i  (pol_we_i),
  .pol_bit_i (pol_bit_i),
  .data_o    (data_o),
  .data_vld_o(data_vld_o),
  .ceo_no    (ceo_no),
  .pol_q     (pol_q),
  .rst_act   (rst_act),
  .addr_q    (addr_q),
  .done_q    (done_q)
);

// File: tb/tb_cfg_bit_streamer.sv
`timescale 1ns/1ps
module tb_cfg_bit_streamer;
  localparam int AW_A = 8;
  localparam int AW_B = 7;
  localparam int D_A  = 1 << AW_A;
  localparam int D_B  = 1 << AW_B;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_ni = 1'b0;
  logic            ce_ni = 1'b1;
  logic            rst_oe = 1'b0;
  logic            ld_we = 1'b0;
  logic [AW_A-1:0] ld_addr = '0;
  logic            ld_bit = 1'b0;
  logic            pol_we = 1'b0;
  logic            pol_bit = 1'b1;

  logic data_a, vld_a, ceo_a;
  logic data_b, vld_b, ceo_b;

  cfg_bit_streamer #(.ADDR_W(AW_A), .SMALLEST_AW(7)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .rst_oe_i(rst_oe),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
    .pol_we_i(pol_we), .pol_bit_i(pol_bit),
    .data_o(data_a), .data_vld_o(vld_a), .ceo_no(ceo_a)
  );

  cfg_bit_streamer #(.ADDR_W(AW_B), .SMALLEST_AW(7)) dut_nc (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .rst_oe_i(rst_oe),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr[AW_B-1:0]), .ld_bit_i(ld_bit),
    .pol_we_i(pol_we), .pol_bit_i(pol_bit),
    .data_o(data_b), .data_vld_o(vld_b), .ceo_no(ceo_b)
  );

  // behavioural reference
  bit ma [D_A];
  bit mb [D_B];
  int a_addr, b_addr;
  bit a_done, b_done;
  bit m_pol;
  int checks = 0;
  int fails = 0;
  string req = "R1";
  bit cmp_on = 1'b0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr = 0; b_addr = 0; a_done = 0; b_done = 0; m_pol = 1;
    end else begin
      bit act;
      act = (rst_oe == m_pol);
      if (act) begin
        a_addr = 0; a_done = 0; b_addr = 0; b_done = 0;
      end else if (!ce_ni) begin
        if (!a_done) begin
          if (a_addr == D_A - 1) begin a_addr = 0; a_done = 1; end
          else a_addr++;
        end
        if (!b_done) begin
          if (b_addr == D_B - 1) begin b_addr = 0; b_done = 1; end
          else b_addr++;
        end
      end
      if (ld_we) begin
        ma[ld_addr] = ld_bit;
        mb[ld_addr[AW_B-1:0]] = ld_bit;
      end
      if (pol_we) m_pol = pol_bit;
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_ni) begin
      bit act, en_a, en_b;
      act  = (rst_oe == m_pol);
      en_a = !ce_ni && !act && !a_done;
      en_b = !ce_ni && !act && !b_done;
      chk(req, "vld_a", vld_a, en_a);
      chk(req, "data_a", data_a, en_a ? ma[a_addr] : 1'b0);
      chk(req, "ceo_a", ceo_a, !a_done);
      chk(req, "vld_b", vld_b, en_b);
      chk(req, "data_b", data_b, en_b ? mb[b_addr] : 1'b0);
      chk("R8", "ceo_b", ceo_b, 1'b1);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    #1;
    chk("R1", "ceo_a after reset", ceo_a, 1'b1);
    chk("R1", "vld_a after reset", vld_a, 1'b0);
    chk("R1", "data_a after reset", data_a, 1'b0);
    // R2: fill both arrays through the load port
    req = "R2";
    @(negedge clk);
    for (int i = 0; i < D_A; i++) begin
      ld_we = 1'b1; ld_addr = AW_A'(i); ld_bit = 1'(((i * 7) ^ (i >> 2)) & 1);
      @(negedge clk);
    end
    ld_we = 1'b0;
    cmp_on = 1'b1;
    cyc(2);
    req = "R3"; ce_ni = 1'b0; cyc(100);
    req = "R6"; ce_ni = 1'b1; cyc(5);
    ce_ni = 1'b0; cyc(20);
    req = "R4"; rst_oe = 1'b1; cyc(2);
    rst_oe = 1'b0; cyc(30);
    req = "R7"; cyc(300);
    chk("R7", "ceo_a held low", ceo_a, 1'b0);
    chk("R8", "ceo_b never low", ceo_b, 1'b1);
    // R5: switch to low-active reset
    req = "R5";
    pol_we = 1'b1; pol_bit = 1'b0; rst_oe = 1'b1; cyc(1);
    pol_we = 1'b0; cyc(3);
    rst_oe = 1'b0; cyc(2);
    rst_oe = 1'b1; cyc(50);
    #1;
    chk("R5", "stream running with low-active reset", vld_a, 1'b1);
    @(negedge clk);
    // R2: rewrite bits while streaming
    req = "R2";
    for (int i = 0; i < 40; i++) begin
      ld_we = 1'b1; ld_addr = AW_A'(60 + i); ld_bit = 1'(i & 1);
      @(negedge clk);
    end
    ld_we = 1'b0;
    req = "R7"; cyc(300);
    req = "R5"; rst_oe = 1'b0; cyc(1);
    rst_oe = 1'b1; cyc(10);
    cmp_on = 1'b0;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule